// File: doc/BRIEF.md
# Tagged-Byte Register Bridge

This block turns a stream of single bytes from a serial slave front end into accesses on a small internal register bus. Every byte that arrives carries its own 2-bit tag. The tag says whether the byte's 6-bit payload selects a register address or is write data for the register already selected. Write data goes out as a payload plus a registered strobe that lasts one cycle. A slave on the internal bus takes the payload when the strobe is high and the current address is its own.

Reads need no tag. When the front end asks for a byte, the bridge returns a whole 8-bit value for the current address and read sub-address, and raises a read-finished pulse. It then steps the sub-address. Loading a new address resets the sub-address to zero, so a register can expose several bytes that are read one after another.

A small bank of demonstration registers is included. Address 0 at sub-address 0 returns a fixed identification byte. Each register in the bank reads back as its 6-bit value with two zero bits on top. Every other address returns zero.

Top module: `tagged_reg_bridge`

## Requirements
- R1: Each received byte is split into a tag in bits [7:6] and a payload in bits [5:0].
- R2: A byte with tag 00 loads its payload into the address register (seen on `bus_addr` after the accepting edge) and sets the read sub-address to 0 on the same edge.
- R3: A byte with tag 01 raises `bus_wr` for exactly one cycle after the accepting edge, with its payload on `bus_wdata`. The address is left unchanged.
- R4: Bytes with tag 10 or 11 are ignored. No strobe is issued, and the address and sub-address keep their values.
- R5: Demonstration register i sits at address REG_BASE+i. It loads `bus_wdata` only on a strobe while `bus_addr` equals its address. All other registers keep their values.
- R6: A read request returns, in the cycle after it, an 8-bit value on `rd_byte` together with a one-cycle `rd_fin` pulse. Address 0 at sub-address 0 gives ID_BYTE. A register address gives {2'b00, value} at any sub-address. Every other combination gives 8'h00.
- R7: Each read request increments the 3-bit sub-address by one, and the count wraps from 7 back to 0.
- R8: The synchronous active-high reset clears the address, the sub-address, the strobe, the read outputs and every register.
- R9: If an address byte and a read request arrive in the same cycle, the read uses the old address and sub-address, and the sub-address ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_byte | input | 8 | Received tagged byte |
| rd_req | input | 1 | Front end requests a read byte |
| rd_byte | output | 8 | Registered read value |
| rd_fin | output | 1 | One-cycle read-finished strobe |
| bus_wr | output | 1 | Internal bus write strobe |
| bus_addr | output | 6 | Internal bus register address |
| bus_wdata | output | 6 | Internal bus write payload |
| bus_sub | output | 3 | Current read sub-address |

## Verification
The bench builds the block with its defaults: three registers starting at address 1 and ID byte C3. With these values the whole 64-entry address space can be swept. Every address is written with a payload computed from the address and read back. This shows that exactly addresses 1 to 3 are mapped and that the write of each address lands only in its own register. The 3-bit sub-address is small enough to drive through a full wrap at address 0. All 128 payloads carrying the two reserved tags are sent, and none of them may disturb the bus.

// File: rtl/rbridge_pkg.sv
package rbridge_pkg;
  localparam int BYTE_W = 8;
  localparam int TAG_W  = 2;
  localparam int PAY_W  = BYTE_W - TAG_W;

  typedef enum logic [TAG_W-1:0] {
    TAG_ADDR = 2'b00,
    TAG_DATA = 2'b01,
    TAG_RSV2 = 2'b10,
    TAG_RSV3 = 2'b11
  } tag_e;
endpackage

// File: rtl/rbridge_decode.sv
module rbridge_decode
  import rbridge_pkg::*;
#(
  parameter int SUB_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rd_req,
  output logic [PAY_W-1:0]  addr,
  output logic [PAY_W-1:0]  wdata,
  output logic              wr,
  output logic [SUB_W-1:0]  sub
);
  tag_e             tag;
  logic [PAY_W-1:0] pay;
  logic             load_addr;

  // R1: tag in the top bits, payload below
  assign tag       = tag_e'(rx_byte[BYTE_W-1 -: TAG_W]);
  assign pay       = rx_byte[PAY_W-1:0];
  assign load_addr = rx_valid && (tag == TAG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      wdata <= '0;
      wr    <= 1'b0;
      sub   <= '0;
    end else begin
      wr <= 1'b0;
      if (rx_valid) begin
        case (tag)
          TAG_ADDR: addr <= pay;
          TAG_DATA: begin
            wr    <= 1'b1;
            wdata <= pay;
          end
          default: ;
        endcase
      end
      if (load_addr)   sub <= '0;
      else if (rd_req) sub <= sub + 1'b1;
    end
  end

  AST_STROBE_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    wr |-> ($past(rx_valid) && $past(rx_byte[7:6]) == 2'b01)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_byte[7:6] == 2'b00) |=> $stable(addr)); // R2
  AST_RESERVED_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_byte[7]) |=> !wr); // R4
  AST_SUB_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !(rx_valid && rx_byte[7:6] == 2'b00))
      |=> sub == SUB_W'($past(sub) + 1'b1)); // R7
  AST_SUB_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_byte[7:6] == 2'b00) |=> sub == '0); // R9
endmodule

// File: rtl/rbridge_bank.sv
module rbridge_bank
  import rbridge_pkg::*;
#(
  parameter int              NREGS    = 3,
  parameter int              REG_BASE = 1,
  parameter logic [BYTE_W-1:0] ID_BYTE = 8'hC3,
  parameter int              SUB_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [PAY_W-1:0]  addr,
  input  logic [PAY_W-1:0]  wdata,
  input  logic [SUB_W-1:0]  sub,
  output logic [BYTE_W-1:0] rdata
);
  localparam int PAD_W = BYTE_W - PAY_W;

  logic [PAY_W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREGS; i++) begin
      if (rst)                                     regs[i] <= '0;
      else if (wr && addr == PAY_W'(REG_BASE + i)) regs[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0 && sub == '0) rdata = ID_BYTE;
    for (int i = 0; i < NREGS; i++)
      if (addr == PAY_W'(REG_BASE + i)) rdata = {{PAD_W{1'b0}}, regs[i]};
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_chk
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(wr && addr == PAY_W'(REG_BASE + g)) |=> $stable(regs[g])); // R5
  end
endmodule

// File: rtl/tagged_reg_bridge.sv
module tagged_reg_bridge
  import rbridge_pkg::*;
#(
  parameter int                NREGS    = 3,
  parameter int                REG_BASE = 1,
  parameter logic [BYTE_W-1:0] ID_BYTE  = 8'hC3,
  parameter int                SUB_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rd_req,
  output logic [7:0]        rd_byte,
  output logic              rd_fin,
  output logic              bus_wr,
  output logic [5:0]        bus_addr,
  output logic [5:0]        bus_wdata,
  output logic [SUB_W-1:0]  bus_sub
);
  logic [BYTE_W-1:0] bank_rdata;

  rbridge_decode #(.SUB_W(SUB_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rd_req   (rd_req),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wr       (bus_wr),
    .sub      (bus_sub)
  );

  rbridge_bank #(
    .NREGS    (NREGS),
    .REG_BASE (REG_BASE),
    .ID_BYTE  (ID_BYTE),
    .SUB_W    (SUB_W)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .sub   (bus_sub),
    .rdata (bank_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_byte <= '0;
      rd_fin  <= 1'b0;
    end else begin
      rd_fin <= rd_req;
      if (rd_req) rd_byte <= bank_rdata;
    end
  end

  AST_FIN_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    rd_fin |-> $past(rd_req)); // R6
  AST_BYTE_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_byte)); // R6
endmodule

// File: tb/tagged_reg_bridge_test.sv
module tagged_reg_bridge_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rd_req = 1'b0;
  logic [7:0] rd_byte;
  logic       rd_fin;
  logic       bus_wr;
  logic [5:0] bus_addr;
  logic [5:0] bus_wdata;
  logic [2:0] bus_sub;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  tagged_reg_bridge uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rd_req(rd_req), .rd_byte(rd_byte), .rd_fin(rd_fin), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sub(bus_sub)
  );

  function automatic logic [5:0] pat(input int a);
    return 6'((a * 5 + 3) % 64);
  endfunction

  function automatic logic [7:0] expect_rd(input int a, input int s, input logic [5:0] v);
    if (a == 0 && s == 0) return 8'hC3;
    if (a >= 1 && a <= 3) return {2'b00, v};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs settled
  task automatic put(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    v = rd_byte;
    chk("R6 rd_fin", int'(rd_fin), 1);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [5:0] val [64];
    repeat (3) @(negedge clk);
    chk("R8 addr", int'(bus_addr), 0);
    chk("R8 sub", int'(bus_sub), 0);
    chk("R8 wr", int'(bus_wr), 0);
    chk("R8 rd_fin", int'(rd_fin), 0);
    chk("R8 rd_byte", int'(rd_byte), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3: write every address
    for (int a = 0; a < 64; a++) begin
      val[a] = pat(a);
      put({2'b00, 6'(a)});
      chk("R2 addr load", int'(bus_addr), a);
      chk("R1 no strobe on addr byte", int'(bus_wr), 0);
      put({2'b01, pat(a)});
      chk("R3 strobe", int'(bus_wr), 1);
      chk("R3 wdata", int'(bus_wdata), int'(pat(a)));
      chk("R3 addr kept", int'(bus_addr), a);
      @(negedge clk);
      chk("R3 one cycle", int'(bus_wr), 0);
    end

    // R5 R6 R7: read every address at sub-address 0
    for (int a = 0; a < 64; a++) begin
      put({2'b00, 6'(a)});
      chk("R2 sub clear", int'(bus_sub), 0);
      rd(v);
      chk("R5/R6 read value", int'(v), int'(expect_rd(a, 0, val[a])));
      chk("R7 sub step", int'(bus_sub), 1);
    end

    // R7 wrap at address 0
    put(8'h00);
    for (int k = 0; k < 9; k++) begin
      rd(v);
      chk("R7/R6 sub read", int'(v), (k % 8 == 0) ? 8'hC3 : 0);
      chk("R7 wrap count", int'(bus_sub), (k + 1) % 8);
    end
    @(negedge clk);
    chk("R6 fin pulse ends", int'(rd_fin), 0);

    // R4 reserved tags
    put(8'h02);
    rd(v);
    for (int t = 2; t < 4; t++) begin
      for (int p = 0; p < 64; p++) begin
        put({2'(t), 6'(p)});
        chk("R4 no strobe", int'(bus_wr), 0);
        chk("R4 addr kept", int'(bus_addr), 2);
        chk("R4 sub kept", int'(bus_sub), 1);
      end
    end
    put(8'h02);
    rd(v);
    chk("R4 reg untouched", int'(v), int'({2'b00, val[2]}));

    // R9 address byte and read together
    put(8'h01);
    rd(v);
    rx_valid = 1'b1; rx_byte = 8'h00; rd_req = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rd_req = 1'b0;
    chk("R9 old address read", int'(rd_byte), int'({2'b00, val[1]}));
    chk("R9 sub zero", int'(bus_sub), 0);
    chk("R9 new address", int'(bus_addr), 0);
    rd(v);
    chk("R9 then id", int'(v), 8'hC3);

    // R8 reset clears registers
    put(8'h03);
    put(8'h7F);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 addr after reset", int'(bus_addr), 0);
    for (int a = 1; a < 4; a++) begin
      put({2'b00, 6'(a)});
      rd(v);
      chk("R8 reg cleared", int'(v), 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule